// File: doc/BRIEF.md
# Dual Shared-Counter PWM Generator

This block turns two 6-bit duty codes into two pulse-width-modulated outputs. A single period counter serves both channels. It advances one step every `STEP_DIV` clocks and wraps after 64 steps. Each channel drives its output high while that shared count is below its own code. Duty therefore runs from 0 to 63/64 of the period in 64 equal steps, and the two channels always start their periods together. With a 50 MHz clock and `STEP_DIV = 156`, the period is about 5 kHz.

Each channel captures its code into a shadow register only at the boundary between two periods, so a code that changes mid-period cannot produce a runt pulse. A shutdown input turns both output enables off, which models a high-impedance pin. It also freezes the shadow codes and clears the counter. When shutdown is released, a fresh period starts from count zero using the codes present at that moment.

Top module: `dual_pwm_gen`

## Requirements
- R1: While reset is held, and on the cycle after it is seen, both output enables and both PWM outputs are low.
- R2: While enabled, output n is high in exactly those cycles where the shared count is below channel n's active code. A period is 64 steps, so a code c gives c×STEP_DIV high cycles followed by (64−c)×STEP_DIV low cycles.
- R3: Code 0 keeps the output low for the whole period. Code 63 keeps it high for all steps except the last one (duty 63/64).
- R4: A code input change takes effect only at the next period boundary. A change that is present at the clock edge ending step 63 applies to the period that edge begins.
- R5: Both channels share one count, so every period begins on the same cycle for both channels. Both outputs are high in its first cycle whenever both codes are nonzero.
- R6: The cycle after shutdown is sampled high, both enables and both outputs are low. They stay low for as long as shutdown is held, whatever the code inputs do. This holds even when shutdown coincides with a period boundary.
- R7: One cycle after shutdown is sampled low, both enables are high and a new period starts at count zero with the codes present at release.
- R8: The shared count advances exactly once every STEP_DIV clocks while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn | input | 1 | Shutdown request, active high |
| code_a | input | 6 | Duty code for channel A |
| code_b | input | 6 | Duty code for channel B |
| pwm_a | output | 1 | PWM output, channel A (meaningful while pwm_a_oe is high) |
| pwm_a_oe | output | 1 | Output enable for channel A; low models high impedance |
| pwm_b | output | 1 | PWM output, channel B |
| pwm_b_oe | output | 1 | Output enable for channel B |

## Verification
Two events can land on the same edge: a period wrap, which loads the shadow codes, and either a code change or a shutdown request. The bench changes both codes in the last cycle of step 63 and expects the following period to show the new duty from its first cycle. It also raises shutdown in that same last cycle and expects the enables to drop on the next cycle, without a new period starting first. Every cycle of each period is compared against the duty predicted from the codes and `STEP_DIV`.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int DEF_CODE_W = 6;
    localparam int NUM_CH     = 2;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef struct packed {
        logic start;   // first running edge after reset or shutdown
        logic active;  // outputs enabled, counter running
        logic hold;    // shutdown requested this cycle
    } ctrl_s;

    function automatic logic count_below(input logic [15:0] cnt,
                                         input logic [15:0] code);
        return cnt < code;
    endfunction

endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
    import dpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shdn,
    output ctrl_s ctrl
);

    run_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RUN_IDLE;
        end else if (shdn) begin
            state_q <= RUN_IDLE;
        end else begin
            state_q <= RUN_ACTIVE;
        end
    end

    always_comb begin
        ctrl.start  = (state_q == RUN_IDLE) && !shdn;
        ctrl.active = (state_q == RUN_ACTIVE);
        ctrl.hold   = shdn;
    end

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int CODE_W   = DEF_CODE_W,
    parameter int STEP_DIV = 156
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_s             ctrl,
    output logic              tick,
    output logic              wrap,
    output logic [CODE_W-1:0] phase
);

    localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(STEP_DIV - 1);
    localparam logic [CODE_W-1:0] PH_LAST  = '1;

    logic [DIV_W-1:0]  div_q;
    logic [CODE_W-1:0] phase_q;

    assign tick  = ctrl.active && !ctrl.hold && (div_q == DIV_LAST);
    assign wrap  = tick && (phase_q == PH_LAST);
    assign phase = phase_q;

    always_ff @(posedge clk) begin
        if (rst || ctrl.hold) begin
            div_q   <= '0;
            phase_q <= '0;
        end else if (ctrl.active) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
            if (tick) begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
    import dpwm_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] phase,
    output logic [CODE_W-1:0] shadow,
    output logic              pwm,
    output logic              oe
);

    logic [CODE_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (load) begin
            shadow_q <= code;
        end
    end

    assign shadow = shadow_q;
    assign oe     = en;
    assign pwm    = en && count_below(16'(phase), 16'(shadow_q));

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import dpwm_pkg::*;
#(
    parameter int CODE_W   = DEF_CODE_W,
    parameter int STEP_DIV = 156
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shdn,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic              pwm_a,
    output logic              pwm_a_oe,
    output logic              pwm_b,
    output logic              pwm_b_oe
);

    ctrl_s             ctrl;
    logic              step_tick;
    logic              period_wrap;
    logic              shadow_load;
    logic [CODE_W-1:0] phase_q;
    logic [CODE_W-1:0] code_w   [NUM_CH];
    logic [CODE_W-1:0] shadow_w [NUM_CH];
    logic              pwm_w    [NUM_CH];
    logic              oe_w     [NUM_CH];

    dpwm_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .shdn (shdn),
        .ctrl (ctrl)
    );

    dpwm_timebase #(
        .CODE_W   (CODE_W),
        .STEP_DIV (STEP_DIV)
    ) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .tick  (step_tick),
        .wrap  (period_wrap),
        .phase (phase_q)
    );

    assign shadow_load = ctrl.start || period_wrap;
    assign code_w[0]   = code_a;
    assign code_w[1]   = code_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dpwm_chan #(
            .CODE_W (CODE_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .load   (shadow_load),
            .en     (ctrl.active),
            .code   (code_w[ch]),
            .phase  (phase_q),
            .shadow (shadow_w[ch]),
            .pwm    (pwm_w[ch]),
            .oe     (oe_w[ch])
        );
    end

    assign pwm_a    = pwm_w[0];
    assign pwm_a_oe = oe_w[0];
    assign pwm_b    = pwm_w[1];
    assign pwm_b_oe = oe_w[1];

endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              shdn,
    input logic              pwm_a,
    input logic              pwm_a_oe,
    input logic              pwm_b,
    input logic              pwm_b_oe,
    input logic              tick,
    input logic [CODE_W-1:0] phase,
    input logic [CODE_W-1:0] shadow_a,
    input logic [CODE_W-1:0] shadow_b
);

    localparam logic [CODE_W-1:0] PH_LAST = '1;

    p_reset_off_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pwm_a_oe && !pwm_b_oe && !pwm_a && !pwm_b));

    p_step_adv_r2: assert property (@(posedge clk) disable iff (rst)
        (pwm_a_oe && !shdn && tick) |=> (phase == CODE_W'($past(phase) + 1'b1)));

    p_zero_dark_r3: assert property (@(posedge clk) disable iff (rst)
        (shadow_a == '0) |-> !pwm_a);

    p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pwm_a_oe && !(tick && phase == PH_LAST)) |=>
            ($stable(shadow_a) && $stable(shadow_b)));

    p_align_r5: assert property (@(posedge clk) disable iff (rst)
        (pwm_a_oe && phase == '0 && shadow_a != '0 && shadow_b != '0) |->
            (pwm_a && pwm_b));

    p_shdn_off_r6: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (!pwm_a_oe && !pwm_b_oe && !pwm_a && !pwm_b));

    p_release_on_r7: assert property (@(posedge clk) disable iff (rst)
        (!shdn && !pwm_a_oe) |=> (pwm_a_oe && pwm_b_oe && phase == '0));

    p_step_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pwm_a_oe && !shdn && !tick) |=> $stable(phase));

endmodule

bind dual_pwm_gen dual_pwm_chk #(
    .CODE_W (CODE_W)
) u_dual_pwm_chk (
    .clk      (clk),
    .rst      (rst),
    .shdn     (shdn),
    .pwm_a    (pwm_a),
    .pwm_a_oe (pwm_a_oe),
    .pwm_b    (pwm_b),
    .pwm_b_oe (pwm_b_oe),
    .tick     (step_tick),
    .phase    (phase_q),
    .shadow_a (shadow_w[0]),
    .shadow_b (shadow_w[1])
);

// File: tb/tb_dual_pwm_gen.sv
module tb_dual_pwm_gen;

    localparam int STEP   = 3;
    localparam int PERIOD = 64 * STEP;
    localparam int NONE   = 9999;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shdn = 1'b1;
    logic [5:0] code_a = '0;
    logic [5:0] code_b = '0;
    logic       pwm_a, pwm_a_oe, pwm_b, pwm_b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_pwm_gen #(
        .CODE_W   (6),
        .STEP_DIV (STEP)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .shdn     (shdn),
        .code_a   (code_a),
        .code_b   (code_b),
        .pwm_a    (pwm_a),
        .pwm_a_oe (pwm_a_oe),
        .pwm_b    (pwm_b),
        .pwm_b_oe (pwm_b_oe)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // outputs seen as {oe_a, pwm_a, oe_b, pwm_b}
    function automatic int outs();
        return {28'd0, pwm_a_oe, pwm_a, pwm_b_oe, pwm_b};
    endfunction

    task automatic check_off(input string tag);
        check_eq(tag, "outputs off", outs(), 0);
    endtask

    // One full period from its first cycle; optional hook after sample chg_k.
    task automatic check_period(input int ea, input int eb, input int chg_k,
                                input int na, input int nb, input bit nsd,
                                input string tag);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int k = 0; k < PERIOD; k++) begin
            int exp_v;
            @(negedge clk);
            exp_v = {28'd0, 1'b1, ((k / STEP) < ea), 1'b1, ((k / STEP) < eb)};
            if (outs() != exp_v) begin
                if (bad == 0) begin
                    first_act = outs();
                    first_exp = exp_v;
                end
                bad++;
            end
            if (k == chg_k) begin
                code_a = 6'(na);
                code_b = 6'(nb);
                shdn   = nsd;
            end
        end
        check_eq(tag, $sformatf("period codes %0d/%0d first mismatch", ea, eb),
                 first_act, first_exp);
    endtask

    task automatic halt_and_release(input int a, input int b);
        @(negedge clk);
        shdn = 1'b1;
        @(negedge clk);
        code_a = 6'(a);
        code_b = 6'(b);
        shdn   = 1'b0;
    endtask

    task automatic t_reset();
        rst  = 1'b1;
        shdn = 1'b1;
        repeat (4) @(negedge clk);
        check_off("R1");
        rst = 1'b0;
        @(negedge clk);
        check_off("R1");
    endtask

    task automatic t_basic();
        halt_and_release(20, 45);
        check_period(20, 45, NONE, 0, 0, 1'b0, "R2");
        check_period(20, 45, NONE, 0, 0, 1'b0, "R8");
        halt_and_release(1, 32);
        check_period(1, 32, NONE, 0, 0, 1'b0, "R5");
    endtask

    task automatic t_extremes();
        halt_and_release(0, 63);
        check_period(0, 63, NONE, 0, 0, 1'b0, "R3");
        halt_and_release(63, 0);
        check_period(63, 0, NONE, 0, 0, 1'b0, "R3");
    endtask

    task automatic t_midchange();
        halt_and_release(10, 50);
        check_period(10, 50, 70, 33, 7, 1'b0, "R4");
        check_period(33, 7, PERIOD - 1, 63, 1, 1'b0, "R4");
        check_period(63, 1, NONE, 0, 0, 1'b0, "R4");
    endtask

    task automatic t_shutdown();
        int lit = 0;
        halt_and_release(40, 12);
        repeat (50) @(negedge clk);
        shdn   = 1'b1;
        code_a = 6'd5;
        code_b = 6'd60;
        @(negedge clk);
        check_off("R6");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            code_a = 6'(i);
            if (outs() != 0) lit++;
        end
        check_eq("R6", "cycles with output on during shutdown", lit, 0);
        code_a = 6'd5;
        shdn   = 1'b0;
        check_period(5, 60, NONE, 0, 0, 1'b0, "R7");
    endtask

    task automatic t_shdn_at_wrap();
        halt_and_release(30, 31);
        check_period(30, 31, PERIOD - 1, 30, 31, 1'b1, "R6");
        @(negedge clk);
        check_off("R6");
        repeat (5) @(negedge clk);
        code_a = 6'd2;
        code_b = 6'd61;
        shdn   = 1'b0;
        check_period(2, 61, NONE, 0, 0, 1'b0, "R7");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_extremes();
        t_midchange();
        t_shutdown();
        t_shdn_at_wrap();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

endmodule